// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Sequencer

This block sequences hardware loops for a processor fetch unit. A loop start command gives an iteration count, the address of the loop's last instruction word and the address of its first word. The block keeps a loop-end address register, a loop counter and a loop-active flag. While the flag is set it compares every fetch address with the loop-end address. When the last word is fetched it either sends fetch back to the loop start, which is read from the top of an external return stack, or lets the loop fall through.

Nesting works through the shared return stack. Each loop start saves the enclosing loop's end address and counter as one entry, and the loop-start address with the status word as a second entry. A loop exit, whether natural or forced by an early-exit command, pulls both entries. The exit restores the loop-active flag from the saved status word and then restores the end address and counter. A single-instruction repeat command loads the counter and holds the sequencer in a repeat phase. During that phase the fetch unit replays its latched instruction and interrupts are held off. When the repeat finishes, the enclosing counter value is put back.

Top module: `hwloop_seq`

## Requirements
- R1: A loop start in the idle phase raises `stk_push` for exactly the next two cycles. The first entry is {old loop_addr, old loop_count}. The second entry is {do_start_pc, sr_in with bit 15 replaced by the loop flag held before the start}.
- R2: One cycle after an accepted loop start, `loop_addr` equals `do_end_addr`, `loop_count` equals `do_count` and `loop_flag` is 1.
- R3: A valid fetch with `loop_flag` set, `fetch_pc` equal to `loop_addr` and `loop_count` not 1 gives the following in the next cycle: a one-cycle `redirect` pulse, `next_pc` equal to `stk_top_hi`, and `loop_count` decremented by one.
- R4: A fetch with a non-matching address, a fetch with `loop_flag` clear, or a match with `fetch_valid` low causes no redirect and leaves `loop_count` unchanged.
- R5: A matching fetch with `loop_count` equal to 1 gives the following in the next cycle: `loop_done` high, `redirect` low, `next_pc` = `loop_addr`+1, and `loop_flag` taken from bit 15 of `stk_top_lo`. `stk_pull` is then high for two cycles. At the end of the second cycle, `loop_addr` and `loop_count` are loaded from the top entry.
- R6: Reset clears `loop_flag`, `loop_addr` and `loop_count` and leaves every strobe low.
- R7: A repeat start with count N (N≥1) in the idle phase holds `rep_active` high for exactly N cycles, starting the cycle after. During those cycles no fetch match redirects. Afterwards `loop_count` returns to its value from before the repeat.
- R8: An early-exit request while `loop_flag` is set pulls two entries in the same way as R5, but raises neither `redirect` nor `loop_done`. With `loop_flag` clear the request is ignored.
- R9: A loop count of 0 runs 65536 passes: the first loop-back leaves `loop_count` at 16'hFFFF.
- R10: At most MAX_NEST (7) loops are open at once. A further loop start is ignored, with no push and no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| do_start | input | 1 | Loop start command |
| do_count | input | 16 | Iteration count (0 means 65536) |
| do_end_addr | input | 16 | Address of the loop's last word |
| do_start_pc | input | 16 | Address of the loop's first word |
| sr_in | input | 16 | Current status word to save |
| enddo_req | input | 1 | Early loop exit request |
| rep_start | input | 1 | Single-instruction repeat command |
| rep_count | input | 16 | Repeat count |
| fetch_valid | input | 1 | A fetch happens this cycle |
| fetch_pc | input | 16 | Address being fetched |
| next_pc | output | 16 | Loop-back target or fall-through address |
| redirect | output | 1 | Fetch must continue at next_pc |
| loop_done | output | 1 | A loop ended naturally |
| rep_active | output | 1 | Repeat in progress: replay latched word, hold interrupts |
| stk_push | output | 1 | Push one entry to the return stack |
| stk_push_hi | output | 16 | High half of the pushed entry |
| stk_push_lo | output | 16 | Low half of the pushed entry |
| stk_pull | output | 1 | Pull one entry from the return stack |
| stk_top_hi | input | 16 | High half of the stack top entry |
| stk_top_lo | input | 16 | Low half of the stack top entry |
| loop_addr | output | 16 | Current loop-end address |
| loop_count | output | 16 | Current loop counter |
| loop_flag | output | 1 | Loop active flag |

## Verification
Register loads, the first push, a redirect or an exit pulse and the restored loop flag are all due one cycle after the command or fetch that causes them. The second push and the second pull come one cycle later, and the restored address and counter three cycles after the exit. A repeat of N keeps `rep_active` high from the cycle after the command for N cycles. The bench changes inputs on the falling edge and reads results at the next falling edge, or at the exact later falling edge for the multi-cycle results. The return stack is modelled behaviourally in the bench, so loop-back targets and restored values come from entries the bench saw pushed.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PUSH_A,
    S_PUSH_B,
    S_PULL_A,
    S_PULL_B,
    S_REP
  } seq_state_t;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_DO_LOAD,
    OP_ITER,
    OP_POP_FLAG,
    OP_POP_REGS,
    OP_REP_LOAD,
    OP_REP_STEP,
    OP_REP_END
  } reg_op_t;

endpackage

// File: rtl/hwloop_match.sv
module hwloop_match #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          lf,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_pc,
  input  logic [AW-1:0] loop_addr,
  input  logic [DW-1:0] loop_count,
  output logic          hit,
  output logic          last
);

  localparam logic [DW-1:0] ONE = DW'(1);

  // Last-word fetch while a loop is open
  assign hit  = lf & fetch_valid & (fetch_pc == loop_addr);
  // The end test looks for one, so a count of zero wraps to a full pass set
  assign last = (loop_count == ONE);

endmodule

// File: rtl/hwloop_regs.sv
module hwloop_regs
  import hwloop_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 16,
  parameter int LF_BIT = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  reg_op_t       op,
  input  logic [AW-1:0] do_end_addr,
  input  logic [DW-1:0] do_count,
  input  logic [DW-1:0] rep_count,
  input  logic [AW-1:0] pop_hi,
  input  logic [DW-1:0] pop_lo,
  output logic [AW-1:0] loop_addr,
  output logic [DW-1:0] loop_count,
  output logic          loop_flag
);

  localparam logic [DW-1:0] ONE = DW'(1);

  logic [DW-1:0] rep_saved;

  always_ff @(posedge clk) begin
    if (rst) begin
      loop_addr  <= '0;
      loop_count <= '0;
      loop_flag  <= 1'b0;
      rep_saved  <= '0;
    end else begin
      case (op)
        OP_DO_LOAD: begin
          loop_addr  <= do_end_addr;
          loop_count <= do_count;
          loop_flag  <= 1'b1;
        end
        OP_ITER:     loop_count <= loop_count - ONE;
        OP_POP_FLAG: loop_flag  <= pop_lo[LF_BIT];
        OP_POP_REGS: begin
          loop_addr  <= pop_hi;
          loop_count <= pop_lo;
        end
        OP_REP_LOAD: begin
          rep_saved  <= loop_count;
          loop_count <= rep_count;
        end
        OP_REP_STEP: loop_count <= loop_count - ONE;
        OP_REP_END:  loop_count <= rep_saved;
        default: ;
      endcase
    end
  end

  assert_reset_clears_R6: assert property (@(posedge clk)
    rst |=> (!loop_flag && loop_count == '0 && loop_addr == '0));

  assert_iter_decrements_R3: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ITER) |=> (loop_count == $past(loop_count) - ONE));

  assert_do_loads_R2: assert property (@(posedge clk) disable iff (rst)
    (op == OP_DO_LOAD) |=> (loop_flag && loop_addr == $past(do_end_addr)));

  assert_restore_regs_R5: assert property (@(posedge clk) disable iff (rst)
    (op == OP_POP_REGS) |=> (loop_addr == $past(pop_hi) && loop_count == $past(pop_lo)));

endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
  import hwloop_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int LF_BIT   = 15,
  parameter int MAX_NEST = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          do_start,
  input  logic [AW-1:0] do_start_pc,
  input  logic [DW-1:0] sr_in,
  input  logic          enddo_req,
  input  logic          rep_start,
  input  logic          hit,
  input  logic          last,
  input  logic          lf,
  input  logic [AW-1:0] loop_addr,
  input  logic [DW-1:0] loop_count,
  input  logic [AW-1:0] top_hi,
  output reg_op_t       op,
  output logic [AW-1:0] next_pc,
  output logic          redirect,
  output logic          loop_done,
  output logic          stk_push,
  output logic [AW-1:0] push_hi,
  output logic [DW-1:0] push_lo,
  output logic          stk_pull,
  output logic          rep_active
);

  localparam int NW = $clog2(MAX_NEST + 1);
  localparam logic [NW-1:0] NEST_CAP = NW'(MAX_NEST);
  localparam logic [NW-1:0] NEST_ONE = NW'(1);

  seq_state_t    state, state_n;
  logic [NW-1:0] depth;
  logic [AW-1:0] hold_pc;
  logic [DW-1:0] hold_sr;
  logic [DW-1:0] sr_saved;
  logic          can_nest;
  logic          natural_exit;

  assign can_nest     = (depth < NEST_CAP);
  assign natural_exit = (state == S_IDLE) && hit && last;
  assign rep_active   = (state == S_REP);

  always_comb begin
    sr_saved         = sr_in;
    sr_saved[LF_BIT] = lf;
  end

  // Command arbitration: loop end first, then start, early exit, repeat
  always_comb begin
    op      = OP_NONE;
    state_n = state;
    case (state)
      S_IDLE: begin
        if (hit) begin
          op      = last ? OP_POP_FLAG : OP_ITER;
          state_n = last ? S_PULL_A : S_IDLE;
        end else if (do_start && can_nest) begin
          op      = OP_DO_LOAD;
          state_n = S_PUSH_A;
        end else if (enddo_req && lf) begin
          op      = OP_POP_FLAG;
          state_n = S_PULL_A;
        end else if (rep_start) begin
          op      = OP_REP_LOAD;
          state_n = S_REP;
        end
      end
      S_PUSH_A: state_n = S_PUSH_B;
      S_PUSH_B: state_n = S_IDLE;
      S_PULL_A: state_n = S_PULL_B;
      S_PULL_B: begin
        op      = OP_POP_REGS;
        state_n = S_IDLE;
      end
      S_REP: begin
        op      = last ? OP_REP_END : OP_REP_STEP;
        state_n = last ? S_IDLE : S_REP;
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      depth     <= '0;
      hold_pc   <= '0;
      hold_sr   <= '0;
      next_pc   <= '0;
      redirect  <= 1'b0;
      loop_done <= 1'b0;
      stk_push  <= 1'b0;
      push_hi   <= '0;
      push_lo   <= '0;
      stk_pull  <= 1'b0;
    end else begin
      state     <= state_n;
      redirect  <= 1'b0;
      loop_done <= 1'b0;

      if (op == OP_ITER) begin
        redirect <= 1'b1;
        next_pc  <= top_hi;
      end
      if (natural_exit) begin
        loop_done <= 1'b1;
        next_pc   <= loop_addr + AW'(1);
      end

      if (op == OP_DO_LOAD)       depth <= depth + NEST_ONE;
      else if (op == OP_POP_FLAG) depth <= depth - NEST_ONE;

      // Two-entry save: enclosing end address/counter, then start PC/status
      if (op == OP_DO_LOAD) begin
        stk_push <= 1'b1;
        push_hi  <= loop_addr;
        push_lo  <= loop_count;
        hold_pc  <= do_start_pc;
        hold_sr  <= sr_saved;
      end else if (state == S_PUSH_A) begin
        push_hi <= hold_pc;
        push_lo <= hold_sr;
      end else if (state == S_PUSH_B) begin
        stk_push <= 1'b0;
      end

      // Two-entry restore
      if (op == OP_POP_FLAG)      stk_pull <= 1'b1;
      else if (state == S_PULL_B) stk_pull <= 1'b0;
    end
  end

  assert_push_pull_excl_R1: assert property (@(posedge clk) disable iff (rst)
    !(stk_push && stk_pull));

  assert_push_pair_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(stk_push) |=> stk_push);

  assert_redirect_in_loop_R3: assert property (@(posedge clk) disable iff (rst)
    redirect |-> lf);

  assert_exit_no_redirect_R5: assert property (@(posedge clk) disable iff (rst)
    loop_done |-> (!redirect && stk_pull));

  assert_rep_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    rep_active |-> (!redirect && !stk_push && !stk_pull));

  assert_nest_cap_R10: assert property (@(posedge clk) disable iff (rst)
    depth <= NEST_CAP);

endmodule

// File: rtl/hwloop_seq.sv
module hwloop_seq
  import hwloop_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int LF_BIT   = 15,
  parameter int MAX_NEST = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          do_start,
  input  logic [DW-1:0] do_count,
  input  logic [AW-1:0] do_end_addr,
  input  logic [AW-1:0] do_start_pc,
  input  logic [DW-1:0] sr_in,
  input  logic          enddo_req,
  input  logic          rep_start,
  input  logic [DW-1:0] rep_count,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_pc,
  output logic [AW-1:0] next_pc,
  output logic          redirect,
  output logic          loop_done,
  output logic          rep_active,
  output logic          stk_push,
  output logic [AW-1:0] stk_push_hi,
  output logic [DW-1:0] stk_push_lo,
  output logic          stk_pull,
  input  logic [AW-1:0] stk_top_hi,
  input  logic [DW-1:0] stk_top_lo,
  output logic [AW-1:0] loop_addr,
  output logic [DW-1:0] loop_count,
  output logic          loop_flag
);

  reg_op_t op;
  logic    hit;
  logic    last;

  hwloop_match #(.AW(AW), .DW(DW)) u_match (
    .lf          (loop_flag),
    .fetch_valid (fetch_valid),
    .fetch_pc    (fetch_pc),
    .loop_addr   (loop_addr),
    .loop_count  (loop_count),
    .hit         (hit),
    .last        (last)
  );

  hwloop_ctrl #(.AW(AW), .DW(DW), .LF_BIT(LF_BIT), .MAX_NEST(MAX_NEST)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .do_start    (do_start),
    .do_start_pc (do_start_pc),
    .sr_in       (sr_in),
    .enddo_req   (enddo_req),
    .rep_start   (rep_start),
    .hit         (hit),
    .last        (last),
    .lf          (loop_flag),
    .loop_addr   (loop_addr),
    .loop_count  (loop_count),
    .top_hi      (stk_top_hi),
    .op          (op),
    .next_pc     (next_pc),
    .redirect    (redirect),
    .loop_done   (loop_done),
    .stk_push    (stk_push),
    .push_hi     (stk_push_hi),
    .push_lo     (stk_push_lo),
    .stk_pull    (stk_pull),
    .rep_active  (rep_active)
  );

  hwloop_regs #(.AW(AW), .DW(DW), .LF_BIT(LF_BIT)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .op          (op),
    .do_end_addr (do_end_addr),
    .do_count    (do_count),
    .rep_count   (rep_count),
    .pop_hi      (stk_top_hi),
    .pop_lo      (stk_top_lo),
    .loop_addr   (loop_addr),
    .loop_count  (loop_count),
    .loop_flag   (loop_flag)
  );

endmodule

// File: tb/hwloop_seq_tb.sv
`timescale 1ns/1ps
module hwloop_seq_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        do_start = 1'b0;
  logic [15:0] do_count = '0;
  logic [15:0] do_end_addr = '0;
  logic [15:0] do_start_pc = '0;
  logic [15:0] sr_in = '0;
  logic        enddo_req = 1'b0;
  logic        rep_start = 1'b0;
  logic [15:0] rep_count = '0;
  logic        fetch_valid = 1'b0;
  logic [15:0] fetch_pc = '0;
  logic [15:0] next_pc;
  logic        redirect, loop_done, rep_active, stk_push, stk_pull, loop_flag;
  logic [15:0] stk_push_hi, stk_push_lo, stk_top_hi, stk_top_lo;
  logic [15:0] loop_addr, loop_count;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  hwloop_seq u_dut (
    .clk(clk), .rst(rst), .do_start(do_start), .do_count(do_count),
    .do_end_addr(do_end_addr), .do_start_pc(do_start_pc), .sr_in(sr_in),
    .enddo_req(enddo_req), .rep_start(rep_start), .rep_count(rep_count),
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .next_pc(next_pc),
    .redirect(redirect), .loop_done(loop_done), .rep_active(rep_active),
    .stk_push(stk_push), .stk_push_hi(stk_push_hi), .stk_push_lo(stk_push_lo),
    .stk_pull(stk_pull), .stk_top_hi(stk_top_hi), .stk_top_lo(stk_top_lo),
    .loop_addr(loop_addr), .loop_count(loop_count), .loop_flag(loop_flag)
  );

  // Behavioural return stack
  logic [15:0] m_hi [0:15];
  logic [15:0] m_lo [0:15];
  logic [3:0]  sp;
  initial for (int i = 0; i < 16; i++) begin m_hi[i] = '0; m_lo[i] = '0; end
  always @(posedge clk) begin
    if (rst) sp <= '0;
    else if (stk_push) begin
      m_hi[sp + 4'd1] <= stk_push_hi;
      m_lo[sp + 4'd1] <= stk_push_lo;
      sp <= sp + 4'd1;
    end else if (stk_pull) sp <= sp - 4'd1;
  end
  assign stk_top_hi = m_hi[sp];
  assign stk_top_lo = m_lo[sp];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_do(input logic [15:0] cnt, ea, spc, sr);
    do_start = 1'b1; do_count = cnt; do_end_addr = ea; do_start_pc = spc; sr_in = sr;
    @(negedge clk);
    do_start = 1'b0;
  endtask

  task automatic pulse_enddo();
    enddo_req = 1'b1;
    @(negedge clk);
    enddo_req = 1'b0;
  endtask

  task automatic fetch_once(input logic [15:0] pc);
    fetch_valid = 1'b1; fetch_pc = pc;
    @(negedge clk);
    fetch_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R6 flag", loop_flag, 0);
    chk("R6 addr", loop_addr, 0);
    chk("R6 count", loop_count, 0);
    chk("R6 strobes", {redirect, loop_done, stk_push, stk_pull, rep_active}, 0);
  endtask

  task automatic t_do_start();
    pulse_do(16'd3, 16'h0105, 16'h0101, 16'h0A5A);
    chk("R2 addr", loop_addr, 16'h0105);
    chk("R2 count", loop_count, 16'd3);
    chk("R2 flag", loop_flag, 1);
    chk("R1 first push", {stk_push, stk_push_hi, stk_push_lo}, {1'b1, 16'h0000, 16'h0000});
    @(negedge clk);
    chk("R1 second push", {stk_push, stk_push_hi, stk_push_lo}, {1'b1, 16'h0101, 16'h0A5A});
    @(negedge clk);
    chk("R1 push ends", stk_push, 0);
  endtask

  task automatic t_nomatch();
    fetch_once(16'h0104);
    chk("R4 other pc", {redirect, loop_count}, {1'b0, 16'd3});
    fetch_valid = 1'b0; fetch_pc = 16'h0105;
    @(negedge clk);
    chk("R4 invalid fetch", {redirect, loop_count}, {1'b0, 16'd3});
  endtask

  task automatic t_iterate();
    fetch_once(16'h0105);
    chk("R3 redirect", {redirect, next_pc}, {1'b1, 16'h0101});
    chk("R3 count", loop_count, 16'd2);
    @(negedge clk);
    chk("R3 single pulse", redirect, 0);
    fetch_once(16'h0105);
    chk("R3 second pass", {redirect, loop_count}, {1'b1, 16'd1});
  endtask

  task automatic t_exit();
    fetch_once(16'h0105);
    chk("R5 done", {loop_done, redirect}, 2'b10);
    chk("R5 next pc", next_pc, 16'h0106);
    chk("R5 flag restored", loop_flag, 0);
    chk("R5 pull 1", stk_pull, 1);
    @(negedge clk);
    chk("R5 pull 2", stk_pull, 1);
    @(negedge clk);
    chk("R5 pull ends", stk_pull, 0);
    chk("R5 regs restored", {loop_addr, loop_count}, {16'h0000, 16'h0000});
    fetch_once(16'h0000);
    chk("R4 flag clear", redirect, 0);
  endtask

  task automatic t_enddo();
    pulse_do(16'd5, 16'h0220, 16'h0210, 16'h0001);
    repeat (2) @(negedge clk);
    pulse_do(16'd2, 16'h0230, 16'h0228, 16'h0000);
    repeat (2) @(negedge clk);
    pulse_enddo();
    chk("R8 inner flag", loop_flag, 1);
    chk("R8 no redirect", {redirect, loop_done, stk_pull}, 3'b001);
    repeat (2) @(negedge clk);
    chk("R8 outer regs", {loop_addr, loop_count}, {16'h0220, 16'd5});
    pulse_enddo();
    chk("R8 outer flag", loop_flag, 0);
    repeat (2) @(negedge clk);
    chk("R8 base regs", {loop_addr, loop_count}, {16'h0000, 16'h0000});
    pulse_enddo();
    chk("R8 ignored when idle", {stk_pull, loop_flag}, 2'b00);
    @(negedge clk);
  endtask

  task automatic t_rep();
    int cycles = 0;
    pulse_do(16'd4, 16'h0300, 16'h02F0, 16'h0000);
    repeat (2) @(negedge clk);
    rep_start = 1'b1; rep_count = 16'd3;
    @(negedge clk);
    rep_start = 1'b0;
    chk("R7 count loaded", loop_count, 16'd3);
    fetch_valid = 1'b1; fetch_pc = 16'h0300;
    while (rep_active && cycles < 10) begin
      cycles++;
      @(negedge clk);
      fetch_valid = 1'b0;
      chk("R7 no redirect", redirect, 0);
    end
    chk("R7 active cycles", cycles, 3);
    chk("R7 count restored", loop_count, 16'd4);
    pulse_enddo();
    repeat (2) @(negedge clk);
  endtask

  task automatic t_zero();
    pulse_do(16'd0, 16'h0400, 16'h03F0, 16'h0000);
    chk("R9 zero loaded", loop_count, 16'd0);
    repeat (2) @(negedge clk);
    fetch_once(16'h0400);
    chk("R9 loops back", {redirect, next_pc}, {1'b1, 16'h03F0});
    chk("R9 wraps", loop_count, 16'hFFFF);
    pulse_enddo();
    repeat (2) @(negedge clk);
  endtask

  task automatic t_nest();
    for (int k = 0; k < 7; k++) begin
      pulse_do(16'd2, 16'h0500 + 16'(k), 16'h0480, 16'h0000);
      repeat (2) @(negedge clk);
    end
    chk("R10 seventh open", {loop_flag, loop_addr}, {1'b1, 16'h0506});
    pulse_do(16'd9, 16'h0999, 16'h0990, 16'h0000);
    chk("R10 no push", stk_push, 0);
    chk("R10 regs kept", {loop_addr, loop_count}, {16'h0506, 16'd2});
    for (int k = 0; k < 7; k++) begin
      pulse_enddo();
      repeat (2) @(negedge clk);
    end
    chk("R10 unwound", {loop_flag, loop_addr}, {1'b0, 16'h0000});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_do_start();
    t_nomatch();
    t_iterate();
    t_exit();
    t_enddo();
    t_rep();
    t_zero();
    t_nest();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule